// File: doc/BRIEF.md
# One-Pulse-Per-Second Interval Validator

The block timestamps a once-per-second pulse against a free-running reference counter and judges whether the reference clock and the pulse agree. The reference counter has a fast low word and a slower extension word that steps each time the low word wraps. Together they form one wide timestamp, 48 bits by default. The pulse input is asynchronous. It passes through a synchroniser and a rising-edge detector, and each detected edge captures the timestamp and a wrapping sequence number into a history ring.

Each new capture is compared with the previous one. The difference is taken modulo the timestamp width, so a counter wrap between two pulses still gives the correct interval. If the interval lies within the nominal count plus or minus nominal/TOL_DIV (±100 ppm by default), the block raises its valid flag and publishes the interval. An interval outside that window clears the history: the failing pulse becomes the only stored sample and the valid flag drops.

As good samples build up, the block reports a longer-baseline measurement. It gives the raw timestamp difference across 1, 10, 100 or 1000 seconds, chosen in steps by the number of stored samples, together with the span length. Software divides one by the other. With fewer than the lowest threshold of samples, no average is reported.

Top module: `pps_validator`

## Requirements
- R1: While reset is asserted and just after it is released, pps_valid, sec_count, good_count, avg_valid, avg_diff and avg_span are all zero.
- R2: The reference timestamp advances by one every clock. Its low LO_W bits wrap to zero, and on that wrap the upper EXT_W bits step by one, so the concatenation {extension, low} behaves as one counter.
- R3: Each rising edge of pps_in produces exactly one capture, however long the input stays high. Each capture advances the sequence number by one, modulo 2^SEQ_W.
- R4: The interval between two captures is newer minus older. When the newer timestamp is numerically smaller, 2^(LO_W+EXT_W) is added first.
- R5: A capture whose interval lies between NOM_COUNT - NOM_COUNT/TOL_DIV and NOM_COUNT + NOM_COUNT/TOL_DIV, both limits included, sets pps_valid and loads sec_count with the interval.
- R6: A capture whose interval lies outside that window clears pps_valid and sets good_count to 1. sec_count keeps its previous value.
- R7: A capture with an empty history (good_count = 0) stores the sample, sets good_count to 1 and leaves pps_valid at 0.
- R8: Each accepted capture increments good_count, which saturates at DEPTH.
- R9: After each capture the span is chosen from good_count as follows: SP3 if at least TH3, else SP2 if at least TH2, else SP1 if at least TH1, else SP0 if at least TH0. avg_diff is then the timestamp difference between the newest sample and the sample that many captures earlier, avg_span is the span, and avg_valid is 1. Below TH0, avg_valid, avg_diff and avg_span are all 0.
- R10: The average outputs update only in the cycle after a capture and hold their values between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that the timestamp counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Asynchronous once-per-second pulse |
| pps_valid | output | 1 | Last interval was inside the accept window |
| sec_count | output | LO_W+EXT_W | Most recent accepted one-second interval, in reference ticks |
| good_count | output | $clog2(DEPTH)+1 | Samples held in the history, saturating at DEPTH |
| avg_valid | output | 1 | avg_diff and avg_span hold a measurement |
| avg_diff | output | LO_W+EXT_W | Timestamp difference across the chosen span |
| avg_span | output | $clog2(SP3+1) | Span length in seconds (captures) |

## Verification
The bench shrinks the block to a 12-bit timestamp (6 low bits, 6 extension bits) with a nominal count of 200 and a window of ±2 ticks. It uses a 4-bit sequence number, a 16-entry ring, thresholds of 3/5/8/12 and spans of 1/2/4/8. With these values the timestamp wraps every twenty or so pulses and the sequence number wraps every sixteen, so both wraps occur many times in a short run. Every span step and fill saturation are also reached. The pulse intervals sweep every value inside the window, including both edges. The run then misses once on each side of the window, rebuilds the history to saturation, and includes a long-high pulse.

// File: rtl/pps_val_pkg.sv
package pps_val_pkg;

  typedef enum logic [2:0] {
    LVL_NONE = 3'd0,
    LVL_0    = 3'd1,
    LVL_1    = 3'd2,
    LVL_2    = 3'd3,
    LVL_3    = 3'd4
  } span_lvl_e;

  // Modular difference of two w-bit timestamps (w < 64).
  function automatic logic [63:0] wrap_diff(input logic [63:0] nw,
                                            input logic [63:0] od,
                                            input int unsigned w);
    logic [63:0] msk;
    logic [63:0] a;
    logic [63:0] b;
    msk = (64'd1 << w) - 64'd1;
    a   = nw & msk;
    b   = od & msk;
    if (a < b) a = a + (64'd1 << w);
    return (a - b) & msk;
  endfunction

  // Inclusive accept window around the nominal count.
  function automatic logic in_window(input logic [63:0] d,
                                     input logic [63:0] nom,
                                     input logic [63:0] tol);
    return (d >= nom - tol) && (d <= nom + tol);
  endfunction

endpackage

// File: rtl/pps_tstamp_ctr.sv
module pps_tstamp_ctr #(
  parameter int unsigned LO_W  = 32,
  parameter int unsigned EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [LO_W-1:0]  lo,
  output logic [EXT_W-1:0] ext
);
  logic lo_top;
  assign lo_top = (lo == {LO_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo  <= '0;
      ext <= '0;
    end else begin
      lo <= lo + 1'b1;
      if (lo_top) ext <= ext + 1'b1;
    end
  end
endmodule

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[0], din};
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
      end
    end
  endgenerate

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pps_hist_ring.sv
module pps_hist_ring #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned W     = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pps_span_sel.sv
module pps_span_sel
  import pps_val_pkg::*;
#(
  parameter int unsigned FW  = 12,
  parameter int unsigned SPW = 10,
  parameter int unsigned TH0 = 10,
  parameter int unsigned TH1 = 20,
  parameter int unsigned TH2 = 200,
  parameter int unsigned TH3 = 1500,
  parameter int unsigned SP0 = 1,
  parameter int unsigned SP1 = 10,
  parameter int unsigned SP2 = 100,
  parameter int unsigned SP3 = 1000
) (
  input  logic [FW-1:0]  fill,
  output span_lvl_e      lvl,
  output logic [SPW-1:0] span
);
  localparam int unsigned THR [4] = '{TH0, TH1, TH2, TH3};
  localparam int unsigned SPN [4] = '{SP0, SP1, SP2, SP3};

  logic [3:0] ge;

  for (genvar i = 0; i < 4; i++) begin : g_cmp
    assign ge[i] = (32'(fill) >= THR[i]);
  end

  // highest satisfied threshold wins
  always_comb begin
    lvl  = LVL_NONE;
    span = '0;
    for (int i = 0; i < 4; i++) begin
      if (ge[i]) begin
        lvl  = span_lvl_e'(3'(i + 1));
        span = SPW'(SPN[i]);
      end
    end
  end
endmodule

// File: rtl/pps_validator.sv
module pps_validator
  import pps_val_pkg::*;
#(
  parameter int unsigned NOM_COUNT   = 50_000_000,
  parameter int unsigned TOL_DIV     = 10_000,
  parameter int unsigned LO_W        = 32,
  parameter int unsigned EXT_W       = 16,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned DEPTH       = 2048,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TH0         = 10,
  parameter int unsigned TH1         = 20,
  parameter int unsigned TH2         = 200,
  parameter int unsigned TH3         = 1500,
  parameter int unsigned SP0         = 1,
  parameter int unsigned SP1         = 10,
  parameter int unsigned SP2         = 100,
  parameter int unsigned SP3         = 1000,
  localparam int unsigned TSW        = LO_W + EXT_W,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned FW         = AW + 1,
  localparam int unsigned SPW        = $clog2(SP3 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pps_in,
  output logic           pps_valid,
  output logic [TSW-1:0] sec_count,
  output logic [FW-1:0]  good_count,
  output logic           avg_valid,
  output logic [TSW-1:0] avg_diff,
  output logic [SPW-1:0] avg_span
);
  localparam int unsigned EW  = SEQ_W + TSW;
  localparam int unsigned TOL = NOM_COUNT / TOL_DIV;

  // ---------------- reference timestamp ----------------
  logic [LO_W-1:0]  tsc_lo;
  logic [EXT_W-1:0] tsc_ext;
  logic [TSW-1:0]   ts_now;

  pps_tstamp_ctr #(.LO_W(LO_W), .EXT_W(EXT_W)) u_tsc (
    .clk(clk), .rst_n(rst_n), .lo(tsc_lo), .ext(tsc_ext)
  );
  assign ts_now = {tsc_ext, tsc_lo};

  // ---------------- pulse capture ----------------
  logic cap_evt;
  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pps_in), .rise(cap_evt)
  );

  logic [TSW-1:0]   last_ts;
  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] seq_nxt;
  logic [AW-1:0]    wptr_q;
  logic [FW-1:0]    fill_q;
  logic [TSW-1:0]   iv;
  logic             iv_ok;
  logic             first_cap;
  logic             good_cap;
  logic             miss_cap;

  assign seq_nxt   = seq_q + 1'b1;
  assign iv        = TSW'(wrap_diff(64'(ts_now), 64'(last_ts), TSW));
  assign iv_ok     = in_window(64'(iv), 64'(NOM_COUNT), 64'(TOL));
  assign first_cap = cap_evt && (fill_q == '0);
  assign good_cap  = cap_evt && (fill_q != '0) && iv_ok;
  assign miss_cap  = cap_evt && (fill_q != '0) && !iv_ok;

  // ---------------- history ring ----------------
  logic [AW-1:0] raddr;
  logic [EW-1:0] rdata;

  pps_hist_ring #(.DEPTH(DEPTH), .W(EW)) u_ring (
    .clk(clk), .we(cap_evt), .waddr(wptr_q), .wdata({seq_nxt, ts_now}),
    .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ts   <= '0;
      seq_q     <= '0;
      wptr_q    <= '0;
      fill_q    <= '0;
      pps_valid <= 1'b0;
      sec_count <= '0;
    end else if (cap_evt) begin
      last_ts <= ts_now;
      seq_q   <= seq_nxt;
      wptr_q  <= wptr_q + 1'b1;
      if (good_cap) begin
        pps_valid <= 1'b1;
        sec_count <= iv;
        if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
      end else begin
        // first sample or a miss: history restarts with this sample
        pps_valid <= 1'b0;
        fill_q    <= FW'(1);
      end
    end
  end

  assign good_count = fill_q;

  // ---------------- long-span measurement (cycle after capture) ----------------
  logic             avg_upd;
  span_lvl_e        lvl;
  logic [SPW-1:0]   span;
  logic [SEQ_W-1:0] old_seq;
  logic [TSW-1:0]   old_ts;
  logic [TSW-1:0]   span_diff;
  logic             seq_ok;

  pps_span_sel #(
    .FW(FW), .SPW(SPW),
    .TH0(TH0), .TH1(TH1), .TH2(TH2), .TH3(TH3),
    .SP0(SP0), .SP1(SP1), .SP2(SP2), .SP3(SP3)
  ) u_span (
    .fill(fill_q), .lvl(lvl), .span(span)
  );

  assign raddr     = wptr_q - 1'b1 - AW'(span);
  assign {old_seq, old_ts} = rdata;
  assign span_diff = TSW'(wrap_diff(64'(last_ts), 64'(old_ts), TSW));
  assign seq_ok    = (SEQ_W'(seq_q - old_seq) == SEQ_W'(span));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avg_upd <= 1'b0;
    else        avg_upd <= cap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_valid <= 1'b0;
      avg_diff  <= '0;
      avg_span  <= '0;
    end else if (avg_upd) begin
      if (lvl != LVL_NONE && seq_ok) begin
        avg_valid <= 1'b1;
        avg_diff  <= span_diff;
        avg_span  <= span;
      end else begin
        avg_valid <= 1'b0;
        avg_diff  <= '0;
        avg_span  <= '0;
      end
    end
  end

  // first_cap is a named event for the checker only
  logic unused_ok;
  assign unused_ok = first_cap;
endmodule

// File: rtl/pps_validator_chk.sv
module pps_validator_chk #(
  parameter int unsigned LO_W   = 32,
  parameter int unsigned EXT_W  = 16,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned TSW    = 48,
  parameter int unsigned FW     = 12,
  parameter int unsigned SPW    = 10,
  parameter int unsigned DEPTH  = 2048,
  parameter longint unsigned WIN_LO = 0,
  parameter longint unsigned WIN_HI = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LO_W-1:0]  tsc_lo,
  input logic [EXT_W-1:0] tsc_ext,
  input logic             cap_evt,
  input logic             first_cap,
  input logic             miss_cap,
  input logic             avg_upd,
  input logic [SEQ_W-1:0] seq_q,
  input logic             pps_valid,
  input logic [TSW-1:0]   sec_count,
  input logic [FW-1:0]    good_count,
  input logic             avg_valid,
  input logic [TSW-1:0]   avg_diff,
  input logic [SPW-1:0]   avg_span
);
  // R2
  ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsc_lo == {LO_W{1'b1}}) |=> (tsc_ext == EXT_W'($past(tsc_ext) + 1'b1)));
  // R2
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsc_lo != {LO_W{1'b1}}) |=> $stable(tsc_ext));
  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));
  // R3
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);
  // R5
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_valid |-> (64'(sec_count) >= WIN_LO && 64'(sec_count) <= WIN_HI));
  // R6
  miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cap |=> (!pps_valid && good_count == FW'(1) && $stable(sec_count)));
  // R7
  first_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_cap |=> (good_count == FW'(1) && !pps_valid));
  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_count <= FW'(DEPTH));
  // R9
  span_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> (avg_span != '0));
  // R10
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(avg_upd) |-> ($stable(avg_diff) && $stable(avg_span) && $stable(avg_valid)));
  // R10
  avg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> avg_upd);
endmodule

bind pps_validator pps_validator_chk #(
  .LO_W(LO_W), .EXT_W(EXT_W), .SEQ_W(SEQ_W), .TSW(TSW), .FW(FW), .SPW(SPW),
  .DEPTH(DEPTH),
  .WIN_LO(64'(NOM_COUNT) - 64'(NOM_COUNT / TOL_DIV)),
  .WIN_HI(64'(NOM_COUNT) + 64'(NOM_COUNT / TOL_DIV))
) u_chk (
  .clk(clk), .rst_n(rst_n), .tsc_lo(tsc_lo), .tsc_ext(tsc_ext),
  .cap_evt(cap_evt), .first_cap(first_cap), .miss_cap(miss_cap),
  .avg_upd(avg_upd), .seq_q(seq_q), .pps_valid(pps_valid),
  .sec_count(sec_count), .good_count(good_count), .avg_valid(avg_valid),
  .avg_diff(avg_diff), .avg_span(avg_span)
);

// File: tb/pps_validator_tb.sv
module pps_validator_tb;
  localparam int NOM = 200;
  localparam int TDV = 100;
  localparam int LOW = 6;
  localparam int EXW = 6;
  localparam int SQW = 4;
  localparam int DEP = 16;
  localparam int TSW = LOW + EXW;
  localparam int FW  = $clog2(DEP) + 1;
  localparam int SPW = $clog2(8 + 1);
  localparam int WLO = NOM - NOM / TDV;
  localparam int WHI = NOM + NOM / TDV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_in = 1'b0;
  logic           pps_valid;
  logic [TSW-1:0] sec_count;
  logic [FW-1:0]  good_count;
  logic           avg_valid;
  logic [TSW-1:0] avg_diff;
  logic [SPW-1:0] avg_span;

  always #5 clk = ~clk;

  pps_validator #(
    .NOM_COUNT(NOM), .TOL_DIV(TDV), .LO_W(LOW), .EXT_W(EXW), .SEQ_W(SQW),
    .DEPTH(DEP), .SYNC_STAGES(2),
    .TH0(3), .TH1(5), .TH2(8), .TH3(12),
    .SP0(1), .SP1(2), .SP2(4), .SP3(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .pps_valid(pps_valid),
    .sec_count(sec_count), .good_count(good_count), .avg_valid(avg_valid),
    .avg_diff(avg_diff), .avg_span(avg_span)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model
  int m_fill  = 0;
  int m_valid = 0;
  int m_sec   = 0;
  int n_iv    = 0;
  int pend_iv = 0;
  int ivs [0:255];

  function automatic int exp_span(input int f);
    if (f >= 12) return 8;
    if (f >= 8)  return 4;
    if (f >= 5)  return 2;
    if (f >= 3)  return 1;
    return 0;
  endfunction

  task automatic pulse(input int width, input int next_iv);
    int sp;
    longint sum;
    longint a_diff;
    @(negedge clk) pps_in = 1'b1;
    repeat (width) @(negedge clk);
    pps_in = 1'b0;
    repeat (12 - width) @(negedge clk);
    if (m_fill == 0) begin
      m_fill = 1; m_valid = 0; n_iv = 0;
    end else if (pend_iv >= WLO && pend_iv <= WHI) begin
      m_valid = 1; m_sec = pend_iv; ivs[n_iv] = pend_iv; n_iv++;
      m_fill = (m_fill + 1 > DEP) ? DEP : m_fill + 1;
    end else begin
      m_valid = 0; m_fill = 1; n_iv = 0;
    end
    sp = exp_span(m_fill);
    sum = 0;
    for (int k = 0; k < sp; k++) sum += ivs[n_iv - 1 - k];
    chk("R5", "pps_valid", longint'(pps_valid), m_valid);
    chk("R4", "sec_count", longint'(sec_count), m_sec);
    chk(width > 3 ? "R3" : "R8", "good_count", longint'(good_count), m_fill);
    chk("R9", "avg_valid", longint'(avg_valid), sp != 0);
    chk("R9", "avg_span", longint'(avg_span), sp);
    chk("R9", "avg_diff", longint'(avg_diff), sum);
    a_diff = longint'(avg_diff);
    repeat (next_iv - 13 - 80) @(negedge clk);
    // R10: outputs hold between captures
    chk("R10", "avg_diff hold", longint'(avg_diff), a_diff);
    repeat (80) @(negedge clk);
    pend_iv = next_iv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "pps_valid", longint'(pps_valid), 0);
    chk("R1", "good_count", longint'(good_count), 0);
    chk("R1", "avg_valid", longint'(avg_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sec_count", longint'(sec_count), 0);
    chk("R1", "avg_diff", longint'(avg_diff), 0);
    chk("R1", "avg_span", longint'(avg_span), 0);

    // R7: first sample after reset
    pulse(3, 200);
    chk("R7", "first good_count", longint'(good_count), 1);
    // R2 R4: intervals sweep the window; timestamp and sequence wrap repeatedly
    for (int i = 0; i < 14; i++) pulse(3, WLO + (i % 5));
    // R6: misses just outside each side
    pulse(3, WHI + 1);
    pulse(3, WLO - 1);
    chk("R6", "miss good_count", longint'(good_count), 1);
    chk("R6", "miss pps_valid", longint'(pps_valid), 0);
    // rebuild to saturation, with one long-high pulse (R3)
    for (int i = 0; i < 22; i++) pulse(i == 7 ? 9 : 2, WHI - (i % 5));
    pulse(3, 200);
    chk("R8", "saturated good_count", longint'(good_count), DEP);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule